// File: doc/BRIEF.md
# Bank-Select Address Extension Unit

This unit widens the reach of a processor whose bus carries only 16 address bits. A small bank register supplies extra high-order bits, and the unit joins them to the processor address to form a wider physical address for the memory system behind it. The processor changes the active bank by writing to one decoded control address. A build-time parameter places that address either in the separate I/O space or in ordinary memory space. Reading the same address returns the bank value.

The top 4 KB of the processor's address space is a shared window. It always lands in physical bank 0 at the same offset, whatever bank is selected. Code that switches banks and services interrupts can live there and stay reachable at all times. The bank register changes only on an explicit write. It never moves when the processor address wraps from the top of its space back to zero.

Each bus cycle lasts one clock. Address, chip-select, write strobe and readback are combinational functions of the current request and the registered bank value. A bank written in one cycle therefore governs translation from the following cycle onward.

Top module: `bank_xlat_top`

## Requirements
- R1: After synchronous reset the bank value is 0. A readback returns 0, and a non-shared memory access at offset A produces physical address A.
- R2: A memory access outside the shared window drives `phys_addr` to the bank value in bits 18:16 and the processor address in bits 15:0.
- R3: A memory access at processor addresses 0xF000 through 0xFFFF drives `phys_addr` bits 18:16 to 0 and bits 15:0 to the processor address, for any bank value.
- R4: A write to the control address loads bits 2:0 of `cpu_wdata` into the bank register. With the default build, the control address is 0x00F0 with `cpu_io`=1.
- R5: A newly written bank value first affects `phys_addr` in the cycle after the write. During the write cycle the old value is used.
- R6: A write or read at the control address keeps `mem_cs` and `mem_we` at 0.
- R7: A read at the control address sets `bank_rd_hit` to 1 and drives `bank_rdata` with the bank value in bits 2:0 and zeros above. In all other cycles `bank_rd_hit` is 0 and `bank_rdata` is 0.
- R8: Stepping the processor address across the wrap from 0xFFFF to 0x0000 leaves the bank value unchanged.
- R9: With the default build, an access at 0x00F0 with `cpu_io`=0 is an ordinary memory access and leaves the bank unchanged. An I/O access at any other address asserts no memory select and leaves the bank unchanged.
- R10: `mem_cs` is 1 exactly for memory-space reads and writes. `mem_we` is 1 exactly for memory-space writes. Both are 0 in idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write cycle request |
| cpu_rd | input | 1 | Read cycle request |
| cpu_io | input | 1 | 1 = I/O space cycle, 0 = memory space cycle |
| phys_addr | output | 19 | Extended physical address |
| mem_cs | output | 1 | Memory chip-select |
| mem_we | output | 1 | Memory write enable |
| bank_rd_hit | output | 1 | Readback of the bank register drives the data |
| bank_rdata | output | 8 | Zero-extended bank readback value |

## Verification
Two functions can act in the same cycle. A bank write can coincide with address formation, and the shared-window bypass can coincide with a non-zero bank. The bench drives a control write and samples `phys_addr` within that same cycle, expecting the old bank. It then checks the next access for the new bank. Accesses inside the shared window are issued right after switching to banks 3, 5 and 7, and a reference model predicts every output on every clock, including across randomized mixes of writes, reads and address wraps.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;

    localparam int CPU_AW_DEF      = 16;
    localparam int BANK_W_DEF      = 3;
    localparam int DATA_W_DEF      = 8;
    localparam int COMMON_BITS_DEF = 4;

    typedef enum logic [2:0] {
        ACC_IDLE     = 3'd0,
        ACC_MEM_RD   = 3'd1,
        ACC_MEM_WR   = 3'd2,
        ACC_CTRL_RD  = 3'd3,
        ACC_CTRL_WR  = 3'd4,
        ACC_IO_OTHER = 3'd5
    } acc_kind_t;

    typedef struct packed {
        logic mem_sel;
        logic mem_write;
        logic reg_load;
        logic reg_read;
    } acc_ctl_t;

    function automatic acc_ctl_t kind_to_ctl(acc_kind_t k);
        acc_ctl_t c;
        c.mem_sel   = (k == ACC_MEM_RD) || (k == ACC_MEM_WR);
        c.mem_write = (k == ACC_MEM_WR);
        c.reg_load  = (k == ACC_CTRL_WR);
        c.reg_read  = (k == ACC_CTRL_RD);
        return c;
    endfunction

endpackage

// File: rtl/bank_ctrl_decode.sv
module bank_ctrl_decode
    import bank_xlat_pkg::*;
#(
    parameter int              CPU_AW     = CPU_AW_DEF,
    parameter logic [CPU_AW-1:0] CTRL_ADDR = 'h00F0,
    parameter bit              CTRL_IN_IO = 1'b1
) (
    input  logic [CPU_AW-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              io,
    output acc_kind_t         kind
);

    logic space_ok;

    generate
        if (CTRL_IN_IO) begin : g_io_space
            assign space_ok = io;
        end else begin : g_mem_space
            assign space_ok = !io;
        end
    endgenerate

    logic ctrl_hit;
    assign ctrl_hit = space_ok && (addr == CTRL_ADDR);

    always_comb begin
        kind = ACC_IDLE;
        if (wr || rd) begin
            if (ctrl_hit)
                kind = wr ? ACC_CTRL_WR : ACC_CTRL_RD;
            else if (io)
                kind = ACC_IO_OTHER;
            else
                kind = wr ? ACC_MEM_WR : ACC_MEM_RD;
        end
    end

endmodule

// File: rtl/bank_sel_reg.sv
module bank_sel_reg
    import bank_xlat_pkg::*;
#(
    parameter int BANK_W = BANK_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank_q
);

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (load)
            bank_q <= wdata[BANK_W-1:0];
    end

    // R4
    bank_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> bank_q == $past(wdata[BANK_W-1:0]));

    // R8
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(bank_q));

endmodule

// File: rtl/bank_addr_form.sv
module bank_addr_form
    import bank_xlat_pkg::*;
#(
    parameter int CPU_AW      = CPU_AW_DEF,
    parameter int BANK_W      = BANK_W_DEF,
    parameter int COMMON_BITS = COMMON_BITS_DEF,
    parameter logic [BANK_W-1:0] COMMON_BANK = '0,
    localparam int PHYS_AW    = CPU_AW + BANK_W
) (
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [BANK_W-1:0]  bank,
    output logic [PHYS_AW-1:0] phys,
    output logic               in_common
);

    generate
        if (COMMON_BITS > 0) begin : g_common
            assign in_common = &cpu_addr[CPU_AW-1 -: COMMON_BITS];
        end else begin : g_no_common
            assign in_common = 1'b0;
        end
    endgenerate

    logic [BANK_W-1:0] eff_bank;
    assign eff_bank = in_common ? COMMON_BANK : bank;
    assign phys     = {eff_bank, cpu_addr};

endmodule

// File: rtl/bank_xlat_top.sv
module bank_xlat_top
    import bank_xlat_pkg::*;
#(
    parameter int CPU_AW      = CPU_AW_DEF,
    parameter int BANK_W      = BANK_W_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int COMMON_BITS = COMMON_BITS_DEF,
    parameter logic [CPU_AW-1:0] CTRL_ADDR = 'h00F0,
    parameter bit CTRL_IN_IO  = 1'b1,
    localparam int PHYS_AW    = CPU_AW + BANK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic               cpu_io,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               mem_cs,
    output logic               mem_we,
    output logic               bank_rd_hit,
    output logic [DATA_W-1:0]  bank_rdata
);

    acc_kind_t         kind;
    acc_ctl_t          ctl;
    logic [BANK_W-1:0] bank_q;
    logic              in_common;

    bank_ctrl_decode #(
        .CPU_AW    (CPU_AW),
        .CTRL_ADDR (CTRL_ADDR),
        .CTRL_IN_IO(CTRL_IN_IO)
    ) i_decode (
        .addr(cpu_addr),
        .rd  (cpu_rd),
        .wr  (cpu_wr),
        .io  (cpu_io),
        .kind(kind)
    );

    assign ctl = kind_to_ctl(kind);

    bank_sel_reg #(
        .BANK_W(BANK_W),
        .DATA_W(DATA_W)
    ) i_bank (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.reg_load),
        .wdata (cpu_wdata),
        .bank_q(bank_q)
    );

    bank_addr_form #(
        .CPU_AW     (CPU_AW),
        .BANK_W     (BANK_W),
        .COMMON_BITS(COMMON_BITS),
        .COMMON_BANK('0)
    ) i_form (
        .cpu_addr (cpu_addr),
        .bank     (bank_q),
        .phys     (phys_addr),
        .in_common(in_common)
    );

    assign mem_cs      = ctl.mem_sel;
    assign mem_we      = ctl.mem_write;
    assign bank_rd_hit = ctl.reg_read;

    generate
        if (DATA_W > BANK_W) begin : g_zext
            assign bank_rdata = ctl.reg_read ? {{(DATA_W-BANK_W){1'b0}}, bank_q} : '0;
        end else begin : g_trunc
            assign bank_rdata = ctl.reg_read ? bank_q[DATA_W-1:0] : '0;
        end
    endgenerate

    // R3
    common_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && in_common) |-> phys_addr[PHYS_AW-1 -: BANK_W] == '0);

    // R6
    ctrl_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_rd_hit || (cpu_wr && !mem_cs && cpu_addr == CTRL_ADDR && cpu_io == CTRL_IN_IO))
            |-> (!mem_cs && !mem_we));

    // R5
    old_bank_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == CTRL_ADDR && cpu_io == CTRL_IN_IO && !in_common)
            |-> phys_addr[PHYS_AW-1 -: BANK_W] == bank_q);

    // R10
    we_implies_cs_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_cs && cpu_wr && !cpu_io));

    // R7
    readback_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_cs, bank_rd_hit}));

endmodule

// File: tb/test_bank_xlat_top.sv
module test_bank_xlat_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_wr, cpu_rd, cpu_io;
    logic [18:0] phys_addr;
    logic        mem_cs, mem_we, bank_rd_hit;
    logic [7:0]  bank_rdata;

    int total = 0;
    int bad   = 0;
    int model_bank = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bank_xlat_top i_bank_xlat_top (
        .clk(clk), .rst(rst),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_io(cpu_io),
        .phys_addr(phys_addr), .mem_cs(mem_cs), .mem_we(mem_we),
        .bank_rd_hit(bank_rd_hit), .bank_rdata(bank_rdata)
    );

    task automatic check(string tag, logic [30:0] act, logic [30:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the edge, compare to the model, update the model.
    task automatic step(string tag, logic [15:0] a, logic [7:0] wd,
                        bit wr, bit rd, bit io);
        logic        ctrl, mem;
        logic [18:0] e_phys;
        logic [30:0] e_vec, a_vec;
        @(posedge clk);
        #1;
        cpu_addr = a; cpu_wdata = wd; cpu_wr = wr; cpu_rd = rd; cpu_io = io;
        #1;
        ctrl   = (wr || rd) && io && (a == 16'h00F0);
        mem    = (wr || rd) && !io;
        e_phys = (a >= 16'hF000) ? {3'd0, a} : {model_bank[2:0], a};
        e_vec  = {e_phys, mem, mem && wr, ctrl && rd,
                  (ctrl && rd) ? {5'd0, model_bank[2:0]} : 8'd0};
        a_vec  = {phys_addr, mem_cs, mem_we, bank_rd_hit, bank_rdata};
        check(tag, a_vec, e_vec);
        if (ctrl && wr) model_bank = int'(wd[2:0]);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cpu_addr = '0; cpu_wdata = '0; cpu_wr = 0; cpu_rd = 0; cpu_io = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        step("R1 readback", 16'h00F0, 8'h00, 0, 1, 1);
        step("R1 phys", 16'h1234, 8'h00, 0, 1, 0);

        // R4 / R5 write bank 5, old bank during the write cycle
        step("R5 write cycle uses old bank", 16'h00F0, 8'h05, 1, 0, 1);
        step("R5 next cycle new bank", 16'h1234, 8'h00, 0, 1, 0);
        step("R2 bank 5 offset", 16'hEFFF, 8'h00, 0, 1, 0);

        // R3 shared window with non-zero bank
        step("R3 window low", 16'hF000, 8'h00, 0, 1, 0);
        step("R3 window high", 16'hFFFF, 8'h11, 1, 0, 0);

        // R7 readback zero-extension; R4 upper data bits ignored
        step("R7 readback 5", 16'h00F0, 8'h00, 0, 1, 1);
        step("R4 load from wdata low bits", 16'h00F0, 8'hFB, 1, 0, 1);
        step("R7 readback 3", 16'h00F0, 8'h00, 0, 1, 1);
        step("R3 window after bank 3", 16'hF800, 8'h00, 0, 1, 0);

        // R8 wrap does not move bank
        step("R8 wrap a", 16'hFFFE, 8'h00, 0, 1, 0);
        step("R8 wrap b", 16'hFFFF, 8'h00, 0, 1, 0);
        step("R8 wrap c", 16'h0000, 8'h00, 0, 1, 0);
        step("R8 wrap d", 16'h0001, 8'h00, 0, 1, 0);
        step("R8 readback", 16'h00F0, 8'h00, 0, 1, 1);

        // R9 memory-space access at control address, other I/O access
        step("R9 mem write at ctrl addr", 16'h00F0, 8'h07, 1, 0, 0);
        step("R9 io other write", 16'h0010, 8'h06, 1, 0, 1);
        step("R9 bank unchanged", 16'h00F0, 8'h00, 0, 1, 1);
        step("R9 phys still bank 3", 16'h2000, 8'h00, 0, 1, 0);

        // R6 control cycles do not touch memory; R10 idle
        step("R6 ctrl write", 16'h00F0, 8'h07, 1, 0, 1);
        step("R3 window after bank 7", 16'hFABC, 8'h00, 0, 1, 0);
        step("R10 idle", 16'h4321, 8'h00, 0, 0, 0);
        step("R10 mem write", 16'h4321, 8'hAA, 1, 0, 0);

        // R2 mixed traffic
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int sel;
            sel = $urandom_range(0, 9);
            d   = 8'($urandom);
            a   = 16'($urandom);
            case (sel)
                0: step("R4 rand ctrl write", 16'h00F0, d, 1, 0, 1);
                1: step("R7 rand readback", 16'h00F0, d, 0, 1, 1);
                2: step("R3 rand window", 16'hF000 | (a & 16'h0FFF), d, 0, 1, 0);
                3: step("R9 rand io", a, d, a[0], !a[0], 1);
                4: step("R10 rand idle", a, d, 0, 0, a[1]);
                default: step("R2 rand mem", a, d, a[0], !a[0], 0);
            endcase
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule